// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers interrupt requests from a set of device lines, eight by default, and presents them to a processor on one request wire. Software sets up the controller through a small byte-wide write port. The port holds an 8-bit level number for each line and selects fixed or rotating priority. When at least one line is active, the controller raises its request. When the processor acknowledges, the controller drops the request and picks the winning line from the inputs as they stand at that moment. It then places that line's level number on the level bus for a single cycle.

After that the controller stays busy. It raises no further request until software writes the end-of-interrupt code. Once it is idle again, it looks at the inputs and requests again if any line is still active. A line that is the only one active is always serviced. Priority decides only between lines that are active at the same time.

Top module: `prio_irq_ctrl`

## Requirements
- R1: Reset state. The request output is low and the level bus is zero. The mode is fixed priority. Each line's level equals its index, and the last-serviced record points at line 7.
- R2: While idle, if any request line is high at a clock edge, the request output is high from that edge on.
- R3: An acknowledge seen while the request output is high drops the request at the next edge. The same edge loads the level bus, which holds the selected level for exactly one cycle. The bus reads zero in every other cycle.
- R4: Fixed mode (mode bit 0). The active line with the lowest index wins.
- R5: Rotating mode (mode bit 1). The search starts at the line just after the last-serviced line and wraps from 7 back to 0. Every serviced acknowledge updates the last-serviced record, in either mode.
- R6: The winner is chosen from the lines as sampled at the acknowledge edge. This includes lines that went high while the request was waiting.
- R7: After an acknowledge, the request output stays low until address 3 is written with byte 0x20. Writes of any other byte to address 3 have no effect.
- R8: After a valid end-of-interrupt, the request output rises again two edges later if any line is still high.
- R9: An acknowledge while the request output is high but no line is active returns the level of line 7.
- R10: Writes with address 0 set the line index from data bits [2:0]. Address 1 sets the level of the indexed line. Address 2 sets the mode from data bit 0.
- R11: An acknowledge while the request output is low is ignored. The level bus stays zero and no request appears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_lines | input | 8 | Device request lines, bit i is line i |
| cpu_ack | input | 1 | Processor acknowledge |
| irq_out | output | 1 | Request to processor |
| lvl_bus | output | 8 | Level of the serviced line, valid one cycle |
| wr_en | input | 1 | Configuration write strobe |
| wr_addr | input | 2 | Configuration register address |
| wr_data | input | 8 | Configuration write data |

## Verification
A vector table sends single-line, two-line, all-line and wrap-around request patterns through a full request, acknowledge and end-of-interrupt cycle. It first uses fixed mode, then rotating mode. Because the rotating entries depend on what was serviced before, they show whether the search start follows the last serviced line. The fixed entries show that history has no effect in fixed mode.

Directed cases cover the following:
- a line that rises after the request;
- an acknowledge with no active line, which returns the line 7 level;
- an acknowledge while idle;
- a wrong end-of-interrupt byte;
- a line still held high across the end-of-interrupt.

// File: rtl/irq_pkg.sv
package irq_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_REQ  = 2'd1,
      ST_BUSY = 2'd2
   } irq_st_t;

   localparam logic [1:0] A_SEL  = 2'd0;
   localparam logic [1:0] A_LVL  = 2'd1;
   localparam logic [1:0] A_MODE = 2'd2;
   localparam logic [1:0] A_EOI  = 2'd3;
endpackage

// File: rtl/irq_cfg.sv
module irq_cfg #(
   parameter int N_LINES  = 8,
   parameter int LVL_W    = 8,
   parameter int DATA_W   = 8,
   parameter int ROT_EN   = 1,
   parameter logic [7:0] EOI_CODE = 8'h20,
   localparam int IDX_W   = $clog2(N_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [LVL_W-1:0]  rd_lvl,
   output logic              rotate,
   output logic              eoi_hit
);
   import irq_pkg::*;

   logic [IDX_W-1:0] sel_q;
   logic [LVL_W-1:0] lvl_tab [N_LINES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sel_q <= '0;
      else if (wr_en && wr_addr == A_SEL) sel_q <= wr_data[IDX_W-1:0];
   end

   for (genvar i = 0; i < N_LINES; i++) begin : g_lvl
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) lvl_tab[i] <= LVL_W'(i);
         else if (wr_en && wr_addr == A_LVL && sel_q == IDX_W'(i))
            lvl_tab[i] <= wr_data[LVL_W-1:0];
      end
   end

   if (ROT_EN != 0) begin : g_rot
      logic mode_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) mode_q <= 1'b0;
         else if (wr_en && wr_addr == A_MODE) mode_q <= wr_data[0];
      end
      assign rotate = mode_q;
   end else begin : g_fix
      assign rotate = 1'b0;
   end

   assign rd_lvl  = lvl_tab[rd_idx];
   assign eoi_hit = wr_en && (wr_addr == A_EOI) && (wr_data[7:0] == EOI_CODE);

   // R10: a level write lands in the indexed entry
   p_lvl_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == A_LVL) |=> lvl_tab[$past(sel_q)] == $past(wr_data[LVL_W-1:0]));
endmodule

// File: rtl/irq_arb.sv
module irq_arb #(
   parameter int N_LINES = 8,
   localparam int IDX_W  = $clog2(N_LINES)
) (
   input  logic [N_LINES-1:0] req,
   input  logic               rotate,
   input  logic [IDX_W-1:0]   last,
   output logic [IDX_W-1:0]   win,
   output logic               found
);
   logic [IDX_W-1:0] base;
   logic [IDX_W-1:0] idx;

   always_comb begin
      base  = rotate ? last + 1'b1 : '0;
      found = 1'b0;
      win   = IDX_W'(N_LINES - 1);
      idx   = '0;
      for (int k = 0; k < N_LINES; k++) begin
         idx = base + k[IDX_W-1:0];
         if (!found && req[idx]) begin
            found = 1'b1;
            win   = idx;
         end
      end
   end

   // R4/R5: the chosen line is active whenever anything is active
   always_comb begin
      if (found) p_grant_active_r4: assert (req[win]);
      if (|req)  p_found_any_r5: assert (found);
   end
endmodule

// File: rtl/irq_seq.sv
module irq_seq #(
   parameter int N_LINES = 8,
   parameter int LVL_W   = 8,
   localparam int IDX_W  = $clog2(N_LINES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               any_req,
   input  logic               cpu_ack,
   input  logic               found,
   input  logic [IDX_W-1:0]   win,
   input  logic [LVL_W-1:0]   win_lvl,
   input  logic               eoi_hit,
   output logic [IDX_W-1:0]   last,
   output logic               irq_out,
   output logic [LVL_W-1:0]   lvl_bus
);
   import irq_pkg::*;

   irq_st_t st_q;
   logic [IDX_W-1:0] last_q;
   logic [LVL_W-1:0] lvl_q;
   logic take;

   assign take = (st_q == ST_REQ) && cpu_ack;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         last_q <= IDX_W'(N_LINES - 1);
         lvl_q  <= '0;
      end else begin
         lvl_q <= take ? win_lvl : '0;
         if (take && found) last_q <= win;
         unique case (st_q)
            ST_IDLE: if (any_req) st_q <= ST_REQ;
            ST_REQ:  if (cpu_ack) st_q <= ST_BUSY;
            ST_BUSY: if (eoi_hit) st_q <= ST_IDLE;
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign last    = last_q;
   assign irq_out = (st_q == ST_REQ);
   assign lvl_bus = lvl_q;

   // R3: request drops right after acknowledge
   p_ack_drops_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_out && cpu_ack) |=> !irq_out);
   // R7: no request while busy without end-of-interrupt
   p_busy_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_BUSY && !eoi_hit) |=> !irq_out);
   // R11: acknowledge while idle leaves the bus at zero
   p_ack_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_out) |=> lvl_bus == '0);
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl #(
   parameter int N_LINES  = 8,
   parameter int LVL_W    = 8,
   parameter int DATA_W   = 8,
   parameter int ROT_EN   = 1,
   parameter logic [7:0] EOI_CODE = 8'h20,
   localparam int IDX_W   = $clog2(N_LINES)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [N_LINES-1:0] req_lines,
   input  logic              cpu_ack,
   output logic              irq_out,
   output logic [LVL_W-1:0]  lvl_bus,
   input  logic              wr_en,
   input  logic [1:0]        wr_addr,
   input  logic [DATA_W-1:0] wr_data
);
   if (N_LINES != (1 << IDX_W) || N_LINES < 2) begin : g_chk_n
      $error("N_LINES must be a power of two, at least 2");
   end
   if (LVL_W > DATA_W || DATA_W < 8) begin : g_chk_w
      $error("LVL_W must fit DATA_W, DATA_W at least 8");
   end

   logic [IDX_W-1:0] win, last;
   logic             found, rotate, eoi_hit;
   logic [LVL_W-1:0] win_lvl;

   irq_cfg #(.N_LINES(N_LINES), .LVL_W(LVL_W), .DATA_W(DATA_W),
             .ROT_EN(ROT_EN), .EOI_CODE(EOI_CODE)) u_cfg (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .rd_idx(win), .rd_lvl(win_lvl),
      .rotate(rotate), .eoi_hit(eoi_hit));

   irq_arb #(.N_LINES(N_LINES)) u_arb (
      .req(req_lines), .rotate(rotate), .last(last),
      .win(win), .found(found));

   irq_seq #(.N_LINES(N_LINES), .LVL_W(LVL_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .any_req(|req_lines), .cpu_ack(cpu_ack),
      .found(found), .win(win), .win_lvl(win_lvl), .eoi_hit(eoi_hit),
      .last(last), .irq_out(irq_out), .lvl_bus(lvl_bus));

   // R3: a nonzero level is shown for one cycle only
   p_lvl_one_cycle_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (lvl_bus != '0) |=> lvl_bus == '0);
   // R2: a request never appears from idle with no line active
   p_req_needs_line_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq_out && req_lines == '0 && !cpu_ack && !eoi_hit) |=> !irq_out);
endmodule

// File: tb/sim_prio_irq_ctrl.sv
`timescale 1ns/1ps
module sim_prio_irq_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req_lines = '0;
   logic       cpu_ack = 1'b0;
   logic       irq_out;
   logic [7:0] lvl_bus;
   logic       wr_en = 1'b0;
   logic [1:0] wr_addr = '0;
   logic [7:0] wr_data = '0;
   int n_chk = 0;
   int n_err = 0;

   always #2.5 clk = ~clk;

   prio_irq_ctrl u0 (.clk(clk), .rst_n(rst_n), .req_lines(req_lines),
      .cpu_ack(cpu_ack), .irq_out(irq_out), .lvl_bus(lvl_bus),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data));

   // entry: {mode, request pattern, expected winning line}
   localparam logic [11:0] VEC [11] = '{
      {1'b0, 8'h01, 3'd0},   // R4 single line
      {1'b0, 8'h88, 3'd3},   // R4 two lines
      {1'b0, 8'h81, 3'd0},   // R4 ends of range
      {1'b0, 8'hF0, 3'd4},   // R4 upper half
      {1'b1, 8'h11, 3'd0},   // R5 after 4: wraps to 0
      {1'b1, 8'h11, 3'd4},   // R5 after 0
      {1'b1, 8'h11, 3'd0},   // R5 after 4 again
      {1'b1, 8'h81, 3'd7},   // R5 after 0: 7 before 0
      {1'b1, 8'h81, 3'd0},   // R5 after 7: wrap
      {1'b0, 8'h82, 3'd1},   // R4 fixed ignores history
      {1'b1, 8'hFF, 3'd2}    // R5 all lines after 1
   };

   task automatic step();
      @(posedge clk); #1;
   endtask

   task automatic chk(input string tag, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_err++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      step();
      wr_en = 1'b0;
   endtask

   task automatic ack_cycle(input string tag, input int exp_lvl);
      cpu_ack = 1'b1;
      step();
      chk({tag, " level"}, lvl_bus, exp_lvl);
      chk({tag, " irq drop R3"}, irq_out, 0);
      cpu_ack = 1'b0;
      step();
      chk({tag, " level one cycle R3"}, lvl_bus, 0);
   endtask

   initial begin
      #1_000_000;
      n_chk++; n_err++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end

   initial begin
      step(); step();
      // R1 reset state
      chk("R1 irq at reset", irq_out, 0);
      chk("R1 level bus at reset", lvl_bus, 0);
      rst_n = 1'b1;
      step();
      // R1 reset levels equal index, fixed mode
      req_lines = 8'h44;
      step();
      chk("R2 irq raised", irq_out, 1);
      ack_cycle("R1 reset level", 2);
      req_lines = '0;
      wr(2'd3, 8'h20);

      // R10 program levels A0+i
      for (int i = 0; i < 8; i++) begin
         wr(2'd0, 8'(i));
         wr(2'd1, 8'hA0 + 8'(i));
      end

      // table walk
      for (int v = 0; v < 11; v++) begin
         wr(2'd2, {7'd0, VEC[v][11]});
         req_lines = VEC[v][10:3];
         step();
         chk($sformatf("R2 vec%0d irq", v), irq_out, 1);
         ack_cycle($sformatf("R4/R5 vec%0d", v), 8'hA0 + VEC[v][2:0]);
         req_lines = '0;
         wr(2'd3, 8'h20);
      end

      // R6 late arrival, fixed mode
      wr(2'd2, 8'h00);
      req_lines = 8'h20;
      step();
      req_lines = 8'h24;
      step();
      ack_cycle("R6 late line", 8'hA2);
      req_lines = '0;
      wr(2'd3, 8'h20);

      // R7/R8 busy hold, wrong code, re-request
      req_lines = 8'h10;
      step();
      ack_cycle("R7 first", 8'hA4);
      step(); step();
      chk("R7 held low while busy", irq_out, 0);
      wr(2'd3, 8'h21);
      step();
      chk("R7 wrong eoi ignored", irq_out, 0);
      wr(2'd3, 8'h20);
      chk("R8 idle right after eoi", irq_out, 0);
      step();
      chk("R8 re-request", irq_out, 1);
      ack_cycle("R8 second", 8'hA4);
      req_lines = '0;
      wr(2'd3, 8'h20);

      // R9 spurious acknowledge
      req_lines = 8'h08;
      step();
      chk("R9 irq", irq_out, 1);
      req_lines = '0;
      ack_cycle("R9 spurious", 8'hA7);
      wr(2'd3, 8'h20);

      // R11 acknowledge while idle
      cpu_ack = 1'b1;
      step();
      chk("R11 level stays zero", lvl_bus, 0);
      chk("R11 no request", irq_out, 0);
      cpu_ack = 1'b0;
      step();
      chk("R11 still idle", irq_out, 0);

      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule